// File: doc/BRIEF.md
# Sound Processor I/O Page Decoder

This block sits on the 8-bit data, 16-bit address bus of a small audio processor. It decodes the sixteen-byte I/O page at 0x00F0–0x00FF. Accesses to that page become select and strobe signals for the surrounding timer bank, the signal-processor register file and the host communication ports. The block itself keeps only three pieces of state: a control register, the signal-processor index register and the ROM overlay switch.

It also arbitrates the top 64 bytes of the address space. There, a boot ROM can be laid over the RAM, and the block chooses which of the two feeds a read. Bus accesses take one cycle. A read strobe or a write strobe arrives together with the address and the write data. Every strobe toward a neighbour is combinational in that same cycle. Read data comes back registered, one cycle after the read strobe, and holds its value until the next read.

Top module: `snd_io_regs`

## Requirements
- R1: After reset, `rom_sel` is 1, `timer_en` is all zero, and a read of 0x00F2 returns 0x00.
- R2: A write to 0x00F1 loads data bits 2:0 into `timer_en`. In that write cycle, `timer_start[i]` pulses only for each timer whose bit goes from 0 to 1.
- R3: A write to 0x00F1 with data bit 4 set pulses `port_clr[0]`, and with bit 5 set pulses `port_clr[1]`, only in the write cycle. These bits are not stored.
- R4: Data bit 7 of a write to 0x00F1 sets `rom_sel`. A read in 0xFFC0–0xFFFF returns `rom_rdata` while `rom_sel` is 1, and `ram_rdata` otherwise.
- R5: A write in 0xFFC0–0xFFFF always asserts `ram_we`, whatever the state of `rom_sel`.
- R6: 0x00F2 is a read/write index register. A read of 0x00F3 asserts `dsp_re`, drives `dsp_addr` with index bits 6:0, and returns `dsp_rdata`.
- R7: A write of 0x00F3 asserts `dsp_we` only when index bit 7 is 0. With index 0x80 or above, the write produces no strobe.
- R8: A write to 0x00FA/0x00FB/0x00FC pulses `prd_we[0/1/2]`. A read of 0x00FD/0x00FE/0x00FF pulses `cnt_rd[0/1/2]` and returns `{4'b0, cnt_val[4i+3:4i]}`. A write to those addresses pulses `cnt_clr[i]`.
- R9: A write to 0x00F0 produces no strobe. Reads of 0x00F0, 0x00F1 and 0x00FA–0x00FC return 0x00.
- R10: 0x00F8, 0x00F9 and every address outside the I/O page and the ROM window act as RAM: a write asserts `ram_we`, and a read returns `ram_rdata`.
- R11: A write to 0x00F4–0x00F7 asserts `port_we`, and a read asserts `port_rd` and returns `port_rdata`. `port_sel` carries address bits 1:0.
- R12: `bus_rdata` changes only at the clock edge that ends a read cycle. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_rd | input | 1 | read strobe |
| bus_wr | input | 1 | write strobe |
| bus_addr | input | 16 | byte address |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | registered read data |
| ram_rdata | input | 8 | RAM data at bus_addr |
| rom_rdata | input | 8 | boot ROM data at bus_addr |
| ram_we | output | 1 | RAM write enable |
| rom_sel | output | 1 | ROM overlay active |
| dsp_addr | output | 7 | signal-processor register index |
| dsp_we | output | 1 | signal-processor register write |
| dsp_re | output | 1 | signal-processor register read |
| dsp_rdata | input | 8 | signal-processor register data |
| port_sel | output | 2 | selected host port |
| port_we | output | 1 | host port write |
| port_rd | output | 1 | host port read |
| port_rdata | input | 8 | host port data |
| port_clr | output | 2 | clear pulses for port pairs 0/1 |
| timer_en | output | 3 | timer enables |
| timer_start | output | 3 | timer restart pulses |
| prd_we | output | 3 | timer period load strobes |
| cnt_rd | output | 3 | counter read (clear-on-read) strobes |
| cnt_clr | output | 3 | counter clear strobes |
| cnt_val | input | 12 | counter values, 4 bits per timer |

## Verification
The hardest case to reach is a write through 0x00F3 that must be dropped. It happens only after the index register has been loaded with a value of 0x80 or more. The index is visible at the ports only through a read of 0x00F2, and only in its low seven bits on `dsp_addr`. The stimulus therefore loads 0x85, reads it back, writes 0x00F3 and expects no strobe. It then reloads 0x05 and confirms that the same write now reaches `dsp_we`. A second hard case is the ROM window, which needs the overlay switched off and back on through control writes before reads in 0xFFC0–0xFFFF can show both sources.

// File: rtl/snd_io_pkg.sv
package snd_io_pkg;
    typedef enum logic [3:0] {
        RG_MEM,
        RG_ROM,
        RG_TEST,
        RG_CTRL,
        RG_IDX,
        RG_DATA,
        RG_PORT,
        RG_PERIOD,
        RG_COUNT
    } region_e;

    localparam int CNT_W = 4;
endpackage

// File: rtl/snd_io_decode.sv
module snd_io_decode
    import snd_io_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] IO_BASE   = 16'h00F0,
    parameter int                ROM_BYTES = 64
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [1:0]        sub
);
    localparam logic [ADDR_W-1:0] ROM_BASE = ADDR_W'((2 ** ADDR_W) - ROM_BYTES);

    logic       io_hit;
    logic [3:0] off;

    assign io_hit = (addr[ADDR_W-1:4] == IO_BASE[ADDR_W-1:4]);
    assign off    = addr[3:0];

    always_comb begin
        region = RG_MEM;
        sub    = off[1:0];
        if (addr >= ROM_BASE) begin
            region = RG_ROM;
        end else if (io_hit) begin
            unique case (off)
                4'h0: region = RG_TEST;
                4'h1: region = RG_CTRL;
                4'h2: region = RG_IDX;
                4'h3: region = RG_DATA;
                4'h4, 4'h5, 4'h6, 4'h7: region = RG_PORT;
                4'h8, 4'h9: region = RG_MEM;
                4'hA, 4'hB, 4'hC: begin
                    region = RG_PERIOD;
                    sub    = off[1:0] - 2'd2;
                end
                default: begin
                    region = RG_COUNT;
                    sub    = off[1:0] - 2'd1;
                end
            endcase
        end
    end
endmodule

// File: rtl/snd_io_ctrl.sv
module snd_io_ctrl
    import snd_io_pkg::*;
#(
    parameter int NTIMER = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  region_e           region,
    input  logic [1:0]        sub,
    input  logic [7:0]        wdata,
    output logic [7:0]        idx_q,
    output logic              rom_on_q,
    output logic [NTIMER-1:0] timer_en_q,
    output logic              ram_we,
    output logic              dsp_we,
    output logic              dsp_re,
    output logic              port_we,
    output logic              port_rd,
    output logic [1:0]        port_clr,
    output logic [NTIMER-1:0] timer_start,
    output logic [NTIMER-1:0] prd_we,
    output logic [NTIMER-1:0] cnt_rd,
    output logic [NTIMER-1:0] cnt_clr
);
    logic ctrl_wr;
    logic unused_bits;

    assign ctrl_wr     = wr && (region == RG_CTRL);
    assign unused_bits = ^{wdata[6], wdata[3]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            rom_on_q   <= 1'b1;
            timer_en_q <= '0;
        end else begin
            if (wr && (region == RG_IDX)) begin
                idx_q <= wdata;
            end
            if (ctrl_wr) begin
                timer_en_q <= wdata[NTIMER-1:0];
                rom_on_q   <= wdata[7];
            end
        end
    end

    assign ram_we      = wr && ((region == RG_MEM) || (region == RG_ROM));
    assign dsp_we      = wr && (region == RG_DATA) && !idx_q[7];
    assign dsp_re      = rd && (region == RG_DATA);
    assign port_we     = wr && (region == RG_PORT);
    assign port_rd     = rd && (region == RG_PORT);
    assign port_clr[0] = ctrl_wr && wdata[4];
    assign port_clr[1] = ctrl_wr && wdata[5];

    for (genvar i = 0; i < NTIMER; i++) begin : g_tmr
        assign timer_start[i] = ctrl_wr && wdata[i] && !timer_en_q[i];
        assign prd_we[i]      = wr && (region == RG_PERIOD) && (sub == 2'(i));
        assign cnt_rd[i]      = rd && (region == RG_COUNT)  && (sub == 2'(i));
        assign cnt_clr[i]     = wr && (region == RG_COUNT)  && (sub == 2'(i));
    end
endmodule

// File: rtl/snd_io_rdmux.sv
module snd_io_rdmux
    import snd_io_pkg::*;
#(
    parameter int NTIMER = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd,
    input  region_e                 region,
    input  logic [1:0]              sub,
    input  logic                    rom_on,
    input  logic [7:0]              idx,
    input  logic [7:0]              ram_rdata,
    input  logic [7:0]              rom_rdata,
    input  logic [7:0]              dsp_rdata,
    input  logic [7:0]              port_rdata,
    input  logic [CNT_W*NTIMER-1:0] cnt_val,
    output logic [7:0]              rdata_q
);
    logic [CNT_W-1:0] cnt_pick;
    logic [7:0]       rd_next;

    always_comb begin
        cnt_pick = '0;
        for (int i = 0; i < NTIMER; i++) begin
            if (sub == 2'(i)) cnt_pick = cnt_val[i*CNT_W +: CNT_W];
        end
    end

    always_comb begin
        unique case (region)
            RG_MEM:    rd_next = ram_rdata;
            RG_ROM:    rd_next = rom_on ? rom_rdata : ram_rdata;
            RG_IDX:    rd_next = idx;
            RG_DATA:   rd_next = dsp_rdata;
            RG_PORT:   rd_next = port_rdata;
            RG_COUNT:  rd_next = {{(8-CNT_W){1'b0}}, cnt_pick};
            default:   rd_next = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= 8'h00;
        else if (rd) rdata_q <= rd_next;
    end
endmodule

// File: rtl/snd_io_regs.sv
module snd_io_regs
    import snd_io_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] IO_BASE   = 16'h00F0,
    parameter int                ROM_BYTES = 64,
    parameter int                NTIMER    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_rd,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    input  logic [7:0]              ram_rdata,
    input  logic [7:0]              rom_rdata,
    output logic                    ram_we,
    output logic                    rom_sel,
    output logic [6:0]              dsp_addr,
    output logic                    dsp_we,
    output logic                    dsp_re,
    input  logic [7:0]              dsp_rdata,
    output logic [1:0]              port_sel,
    output logic                    port_we,
    output logic                    port_rd,
    input  logic [7:0]              port_rdata,
    output logic [1:0]              port_clr,
    output logic [NTIMER-1:0]       timer_en,
    output logic [NTIMER-1:0]       timer_start,
    output logic [NTIMER-1:0]       prd_we,
    output logic [NTIMER-1:0]       cnt_rd,
    output logic [NTIMER-1:0]       cnt_clr,
    input  logic [CNT_W*NTIMER-1:0] cnt_val
);
    region_e    region;
    logic [1:0] sub;
    logic [7:0] dsp_idx_q;

    snd_io_decode #(
        .ADDR_W   (ADDR_W),
        .IO_BASE  (IO_BASE),
        .ROM_BYTES(ROM_BYTES)
    ) u_dec (
        .addr  (bus_addr),
        .region(region),
        .sub   (sub)
    );

    snd_io_ctrl #(
        .NTIMER(NTIMER)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (bus_rd),
        .wr         (bus_wr),
        .region     (region),
        .sub        (sub),
        .wdata      (bus_wdata),
        .idx_q      (dsp_idx_q),
        .rom_on_q   (rom_sel),
        .timer_en_q (timer_en),
        .ram_we     (ram_we),
        .dsp_we     (dsp_we),
        .dsp_re     (dsp_re),
        .port_we    (port_we),
        .port_rd    (port_rd),
        .port_clr   (port_clr),
        .timer_start(timer_start),
        .prd_we     (prd_we),
        .cnt_rd     (cnt_rd),
        .cnt_clr    (cnt_clr)
    );

    snd_io_rdmux #(
        .NTIMER(NTIMER)
    ) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (bus_rd),
        .region    (region),
        .sub       (sub),
        .rom_on    (rom_sel),
        .idx       (dsp_idx_q),
        .ram_rdata (ram_rdata),
        .rom_rdata (rom_rdata),
        .dsp_rdata (dsp_rdata),
        .port_rdata(port_rdata),
        .cnt_val   (cnt_val),
        .rdata_q   (bus_rdata)
    );

    assign dsp_addr = dsp_idx_q[6:0];
    assign port_sel = sub;
endmodule

// File: rtl/snd_io_regs_chk.sv
module snd_io_regs_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] IO_BASE   = 16'h00F0,
    parameter int                ROM_BYTES = 64,
    parameter int                NTIMER    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              ram_we,
    input logic              rom_sel,
    input logic              dsp_we,
    input logic [NTIMER-1:0] timer_en,
    input logic [7:0]        idx
);
    localparam logic [ADDR_W-1:0] ROM_BASE = ADDR_W'((2 ** ADDR_W) - ROM_BYTES);
    localparam logic [ADDR_W-1:0] A_TEST   = IO_BASE;
    localparam logic [ADDR_W-1:0] A_CTRL   = IO_BASE + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_DATA   = IO_BASE + ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_PRD0   = IO_BASE + ADDR_W'(10);
    localparam logic [ADDR_W-1:0] A_PRD2   = IO_BASE + ADDR_W'(12);

    // R1: reset leaves overlay on, timers off, index cleared
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (rom_sel && (timer_en == '0) && (idx == 8'h00)));

    // R2 and R4: control write latches enables and overlay bit
    a_r2_ctrl_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL) |=>
        (timer_en == $past(bus_wdata[NTIMER-1:0])) && (rom_sel == $past(bus_wdata[7])));

    // R5: ROM window writes always reach RAM
    a_r5_rom_write_through: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr >= ROM_BASE) |-> ram_we);

    // R7: data-window write with high index is dropped
    a_r7_drop_high_index: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DATA && idx[7]) |-> !dsp_we);

    // R9: write-only locations read as zero
    a_r9_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == A_TEST || bus_addr == A_CTRL ||
                    (bus_addr >= A_PRD0 && bus_addr <= A_PRD2))) |=> (bus_rdata == 8'h00));

    // R12: read data holds when no read is issued
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind snd_io_regs snd_io_regs_chk #(
    .ADDR_W   (ADDR_W),
    .IO_BASE  (IO_BASE),
    .ROM_BYTES(ROM_BYTES),
    .NTIMER   (NTIMER)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .ram_we   (ram_we),
    .rom_sel  (rom_sel),
    .dsp_we   (dsp_we),
    .timer_en (timer_en),
    .idx      (dsp_idx_q)
);

// File: tb/snd_io_regs_bench.sv
module snd_io_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  ram_rdata, rom_rdata, dsp_rdata, port_rdata;
    logic        ram_we, rom_sel, dsp_we, dsp_re, port_we, port_rd;
    logic [6:0]  dsp_addr;
    logic [1:0]  port_sel, port_clr;
    logic [2:0]  timer_en, timer_start, prd_we, cnt_rd, cnt_clr;
    logic [11:0] cnt_val = 12'h321;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    // neighbour models
    assign ram_rdata  = bus_addr[7:0] ^ 8'h3C;
    assign rom_rdata  = bus_addr[7:0] ^ 8'hC3;
    assign dsp_rdata  = {1'b1, dsp_addr} ^ 8'h40;
    assign port_rdata = {4'h5, 2'b00, port_sel};

    snd_io_regs u_snd_io_regs (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ram_rdata(ram_rdata), .rom_rdata(rom_rdata), .ram_we(ram_we),
        .rom_sel(rom_sel), .dsp_addr(dsp_addr), .dsp_we(dsp_we), .dsp_re(dsp_re),
        .dsp_rdata(dsp_rdata), .port_sel(port_sel), .port_we(port_we),
        .port_rd(port_rd), .port_rdata(port_rdata), .port_clr(port_clr),
        .timer_en(timer_en), .timer_start(timer_start), .prd_we(prd_we),
        .cnt_rd(cnt_rd), .cnt_clr(cnt_clr), .cnt_val(cnt_val)
    );

    // strobe word: ram_we,dsp_we,dsp_re,port_we,port_rd,prd_we[2:0],cnt_rd[2:0],cnt_clr[2:0],port_clr[1:0],timer_start[2:0]
    logic [18:0] strobes;
    assign strobes = {ram_we, dsp_we, dsp_re, port_we, port_rd, prd_we, cnt_rd, cnt_clr, port_clr, timer_start};

    localparam logic [1:0]  OP_WR = 2'b01, OP_RD = 2'b10;
    localparam logic [18:0] S_NONE = 19'h0, S_RAM = 19'h40000, S_DWE = 19'h20000,
                            S_DRE = 19'h10000, S_PWE = 19'h08000, S_PRD = 19'h04000,
                            S_PER1 = 19'h01000, S_CRD1 = 19'h00200, S_CRD0 = 19'h00100,
                            S_CCLR2 = 19'h00080, S_PCLR = 19'h00018;
    localparam int NV = 28;
    // row: req(4) op(2) addr(16) data(8) strobes(19) rdata(8)
    localparam logic [56:0] TBL [NV] = '{
        {4'd1,  OP_RD, 16'h00F2, 8'h00, S_NONE,  8'h00},  // R1 index after reset
        {4'd4,  OP_RD, 16'hFFC0, 8'h00, S_NONE,  8'h03},  // R4 overlay on
        {4'd2,  OP_WR, 16'h00F1, 8'h03, 19'h3,   8'h00},  // R2 start t0,t1
        {4'd2,  OP_WR, 16'h00F1, 8'h07, 19'h4,   8'h00},  // R2 start t2 only
        {4'd3,  OP_WR, 16'h00F1, 8'h37, S_PCLR,  8'h00},  // R3 both port pairs
        {4'd4,  OP_RD, 16'hFFC0, 8'h00, S_NONE,  8'hFC},  // R4 overlay off
        {4'd4,  OP_WR, 16'h00F1, 8'h87, S_NONE,  8'h00},  // R4 overlay back on
        {4'd4,  OP_RD, 16'hFFFF, 8'h00, S_NONE,  8'h3C},  // R4
        {4'd5,  OP_WR, 16'hFFF0, 8'h12, S_RAM,   8'h00},  // R5 write-through
        {4'd6,  OP_WR, 16'h00F2, 8'h85, S_NONE,  8'h00},  // R6
        {4'd6,  OP_RD, 16'h00F2, 8'h00, S_NONE,  8'h85},  // R6
        {4'd7,  OP_WR, 16'h00F3, 8'h11, S_NONE,  8'h00},  // R7 dropped
        {4'd6,  OP_RD, 16'h00F3, 8'h00, S_DRE,   8'hC5},  // R6 masked index
        {4'd6,  OP_WR, 16'h00F2, 8'h05, S_NONE,  8'h00},  // R6
        {4'd7,  OP_WR, 16'h00F3, 8'h22, S_DWE,   8'h00},  // R7 accepted
        {4'd8,  OP_WR, 16'h00FB, 8'h10, S_PER1,  8'h00},  // R8
        {4'd8,  OP_RD, 16'h00FE, 8'h00, S_CRD1,  8'h02},  // R8
        {4'd8,  OP_RD, 16'h00FD, 8'h00, S_CRD0,  8'h01},  // R8
        {4'd8,  OP_WR, 16'h00FF, 8'h00, S_CCLR2, 8'h00},  // R8
        {4'd9,  OP_WR, 16'h00F0, 8'hFF, S_NONE,  8'h00},  // R9 test reg ignored
        {4'd9,  OP_RD, 16'h00F0, 8'h00, S_NONE,  8'h00},  // R9
        {4'd9,  OP_RD, 16'h00F1, 8'h00, S_NONE,  8'h00},  // R9
        {4'd9,  OP_RD, 16'h00FC, 8'h00, S_NONE,  8'h00},  // R9
        {4'd10, OP_WR, 16'h00F8, 8'h5A, S_RAM,   8'h00},  // R10
        {4'd10, OP_RD, 16'h00F9, 8'h00, S_NONE,  8'hC5},  // R10
        {4'd10, OP_RD, 16'h1234, 8'h00, S_NONE,  8'h08},  // R10
        {4'd11, OP_WR, 16'h00F5, 8'h77, S_PWE,   8'h00},  // R11
        {4'd11, OP_RD, 16'h00F6, 8'h00, S_PRD,   8'h52}   // R11
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d,
                          input logic [18:0] exp_s, input logic [7:0] exp_r, input int req);
        @(negedge clk);
        bus_rd = (op == OP_RD);
        bus_wr = (op == OP_WR);
        bus_addr = a;
        bus_wdata = d;
        #1;
        check($sformatf("R%0d strobes @%h", req, a), 32'(strobes), 32'(exp_s));
        @(posedge clk);
        #1;
        bus_rd = 1'b0;
        bus_wr = 1'b0;
        if (op == OP_RD) check($sformatf("R%0d rdata @%h", req, a), 32'(bus_rdata), 32'(exp_r));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 rom_sel after reset", 32'(rom_sel), 32'd1);
        check("R1 timer_en after reset", 32'(timer_en), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            access(TBL[i][52:51], TBL[i][50:35], TBL[i][34:27], TBL[i][26:8], TBL[i][7:0], int'(TBL[i][56:53]));
        end

        // R12: read data held through idle cycles and non-read accesses
        repeat (3) @(posedge clk);
        #1;
        check("R12 hold idle", 32'(bus_rdata), 32'h52);
        access(OP_WR, 16'h00F2, 8'h33, S_NONE, 8'h00, 12);
        check("R12 hold after write", 32'(bus_rdata), 32'h52);

        // R2: enable levels and selective restart
        access(OP_WR, 16'h00F1, 8'h05, S_NONE, 8'h00, 2);
        check("R2 timer_en level", 32'(timer_en), 32'h5);
        check("R4 overlay cleared", 32'(rom_sel), 32'd0);
        access(OP_WR, 16'h00F1, 8'h07, 19'h2, 8'h00, 2);

        // R3: clear bits are not retained
        access(OP_WR, 16'h00F1, 8'hB7, S_PCLR, 8'h00, 3);
        @(negedge clk);
        #1;
        check("R3 port_clr idle", 32'(port_clr), 32'd0);

        // R5: ROM window write with overlay on and off
        access(OP_WR, 16'hFFC0, 8'h01, S_RAM, 8'h00, 5);
        access(OP_WR, 16'h00F1, 8'h00, S_NONE, 8'h00, 4);
        access(OP_WR, 16'hFFFF, 8'h02, S_RAM, 8'h00, 5);

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 rom_sel re-reset", 32'(rom_sel), 32'd1);
        check("R1 timer_en re-reset", 32'(timer_en), 32'd0);
        check("R1 rdata re-reset", 32'(bus_rdata), 32'd0);
        rst_n = 1'b1;
        access(OP_RD, 16'h00F2, 8'h00, S_NONE, 8'h00, 1);
        access(OP_RD, 16'hFFC1, 8'h00, S_NONE, 8'h02, 1);

        finish_run();
    end
endmodule